// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator with Phase Offset

This block synthesises a complex sinusoid. A 32-bit phase accumulator advances by a programmable frequency word on every enabled clock. A 16-bit phase offset is added to the accumulated phase to form the argument. The top 12 bits of the argument address a folded quarter-wave table, which returns signed cosine and sine samples. The tuning step is the clock rate divided by 2^32.

Software loads the frequency word and the offset through a 16-bit write port. Writes first land in shadow registers and move to the active registers only on a clock with the load enable high, so both frequency halves and the offset change together. Per-cycle controls gate accumulation, restart the phase, force the offset to zero, and feed a carry into the accumulator. A registered carry output lets accumulators be chained.

The write port is a two-state machine. In WP_IDLE the strobe is low. The transition WP_IDLE→WP_HIGH happens on the first clock that sees the strobe high, and that clock captures the write. The transition WP_HIGH→WP_IDLE happens on the first clock that sees the strobe low. No capture happens while the machine is in WP_HIGH.

Top module: `nco_quad`

## Requirements
- R1: Synchronous reset (rst high on a clock edge) clears the phase, the shadow and active registers, carry_out, cos_out and sin_out to zero.
- R2: A write is captured only on the clock that moves the port from WP_IDLE to WP_HIGH, and only when sel is high. Address 0 loads the low frequency half, address 1 the high half, and address 2 the offset. Address 3 and writes with sel low change nothing. A strobe held high for several clocks captures only once.
- R3: The active frequency and offset take the shadow values only on a clock with load_en high. A write captured on that same edge is not transferred until a later load.
- R4: With acc_en high and restart low, phase becomes phase + frequency + carry_in modulo 2^32. With both low, phase holds.
- R5: carry_out is the registered carry out of the R4 sum. It is 0 after any clock where acc_en is low or restart is high.
- R6: restart has priority over acc_en. On a clock with restart high, phase becomes frequency + carry_in modulo 2^32.
- R7: The argument register takes the upper 12 bits of phase + (offset << 16). On a clock with ofs_clr high the offset term is zero.
- R8: For argument a (12 bits), sin_out = round(32767·sin(θ)) and cos_out = round(32767·cos(θ)), where θ = (a + 0.5)·2π/4096 and rounding is half away from zero. The top 2 bits of a select the quadrant; the lower 10 bits index a 1024-entry table.
- R9: A control or phase change sampled at clock edge n reaches the argument at edge n+1 and cos_out/sin_out at edge n+3. The outputs stay unchanged at edges n+1 and n+2.
- R10: cos_out and sin_out never take the value -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe; the write is taken on its first sampled high clock |
| sel | input | 1 | Write select, active high |
| addr | input | 2 | Write register address |
| wdata | input | 16 | Write data |
| load_en | input | 1 | Transfer shadow registers to active registers |
| acc_en | input | 1 | Accumulate enable |
| restart | input | 1 | Reload phase from frequency word plus carry_in |
| carry_in | input | 1 | Carry into the accumulator sum |
| ofs_clr | input | 1 | Force the offset term to zero for this cycle |
| carry_out | output | 1 | Registered carry out of the accumulator |
| cos_out | output | 16 | Signed cosine sample |
| sin_out | output | 16 | Signed sine sample |

## Verification
The shadow write and the shadow-to-active load can fall on the same clock edge. The bench provokes this by raising the strobe, with a new offset, in the same cycle as load_en. It then judges the overlap by the output angle: the active offset must still hold the earlier shadow value, and only a second load may bring in the new one. A second overlap pits restart against acc_en. With both high, the phase must equal the frequency word, carry_out must read 0, and the accumulated sum must not appear.

// File: rtl/nco_pkg.sv
package nco_pkg;
    typedef enum logic {
        WP_IDLE = 1'b0,
        WP_HIGH = 1'b1
    } wport_state_t;

    localparam logic [1:0] ADR_FREQ_LO = 2'd0;
    localparam logic [1:0] ADR_FREQ_HI = 2'd1;
    localparam logic [1:0] ADR_OFFSET  = 2'd2;
endpackage

// File: rtl/nco_wport.sv
module nco_wport
    import nco_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic             sel,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] sh_freq_lo,
    output logic [BUS_W-1:0] sh_freq_hi,
    output logic [BUS_W-1:0] sh_offset
);
    wport_state_t state_q, state_d;
    logic         capture;

    always_ff @(posedge clk) begin
        if (rst) state_q <= WP_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            WP_IDLE: begin
                if (wr_stb) begin
                    state_d = WP_HIGH;
                    capture = sel;
                end
            end
            WP_HIGH: begin
                if (!wr_stb) state_d = WP_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_freq_lo <= '0;
            sh_freq_hi <= '0;
            sh_offset  <= '0;
        end else if (capture) begin
            unique case (addr)
                ADR_FREQ_LO: sh_freq_lo <= wdata;
                ADR_FREQ_HI: sh_freq_hi <= wdata;
                ADR_OFFSET:  sh_offset  <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nco_phase.sv
module nco_phase #(
    parameter int BUS_W = 16,
    parameter int ARG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [BUS_W-1:0] sh_freq_lo,
    input  logic [BUS_W-1:0] sh_freq_hi,
    input  logic [BUS_W-1:0] sh_offset,
    input  logic             acc_en,
    input  logic             restart,
    input  logic             carry_in,
    input  logic             ofs_clr,
    output logic [2*BUS_W-1:0] phase_q,
    output logic [ARG_W-1:0] arg_q,
    output logic             carry_out
);
    localparam int ACC_W = 2 * BUS_W;

    logic [ACC_W-1:0] freq_act;
    logic [BUS_W-1:0] ofs_act;
    logic [ACC_W:0]   acc_sum;
    logic [ACC_W-1:0] ofs_term;
    logic [ACC_W-1:0] arg_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_act <= '0;
            ofs_act  <= '0;
        end else if (load_en) begin
            freq_act <= {sh_freq_hi, sh_freq_lo};
            ofs_act  <= sh_offset;
        end
    end

    always_comb begin
        acc_sum  = {1'b0, phase_q} + {1'b0, freq_act} + {{ACC_W{1'b0}}, carry_in};
        ofs_term = ofs_clr ? '0 : {ofs_act, {(ACC_W-BUS_W){1'b0}}};
        arg_full = phase_q + ofs_term;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= '0;
            carry_out <= 1'b0;
            arg_q     <= '0;
        end else begin
            arg_q <= arg_full[ACC_W-1 -: ARG_W];
            if (restart) begin
                phase_q   <= freq_act + {{(ACC_W-1){1'b0}}, carry_in};
                carry_out <= 1'b0;
            end else if (acc_en) begin
                phase_q   <= acc_sum[ACC_W-1:0];
                carry_out <= acc_sum[ACC_W];
            end else begin
                carry_out <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
    parameter int LUT_AW = 10,
    parameter int OUT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LUT_AW+1:0]       arg,
    output logic signed [OUT_W-1:0] cos_out,
    output logic signed [OUT_W-1:0] sin_out
);
    localparam int  DEPTH = 1 << LUT_AW;
    localparam int  MAG_W = OUT_W - 1;
    localparam real PI    = 3.14159265358979323846;
    localparam real STEP  = PI / (2.0 * DEPTH);
    localparam real FULL  = (2.0 ** MAG_W) - 1.0;

    logic [MAG_W-1:0]  rom [DEPTH];
    logic [LUT_AW-1:0] idx;
    logic [1:0]        quad_q;
    logic [MAG_W-1:0]  mag_s_q, mag_c_q;
    logic signed [OUT_W-1:0] ps, pc;

    for (genvar gk = 0; gk < DEPTH; gk++) begin : g_rom
        assign rom[gk] = MAG_W'($rtoi($sin((real'(gk) + 0.5) * STEP) * FULL + 0.5));
    end

    assign idx = arg[LUT_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            quad_q  <= '0;
            mag_s_q <= '0;
            mag_c_q <= '0;
        end else begin
            quad_q  <= arg[LUT_AW+1:LUT_AW];
            mag_s_q <= rom[idx];
            mag_c_q <= rom[~idx];
        end
    end

    assign ps = OUT_W'({1'b0, mag_s_q});
    assign pc = OUT_W'({1'b0, mag_c_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            cos_out <= '0;
            sin_out <= '0;
        end else begin
            unique case (quad_q)
                2'd0: begin sin_out <= ps;  cos_out <= pc;  end
                2'd1: begin sin_out <= pc;  cos_out <= -ps; end
                2'd2: begin sin_out <= -ps; cos_out <= -pc; end
                2'd3: begin sin_out <= -pc; cos_out <= ps;  end
            endcase
        end
    end
endmodule

// File: rtl/nco_quad.sv
module nco_quad #(
    parameter int BUS_W  = 16,
    parameter int LUT_AW = 10,
    parameter int OUT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_stb,
    input  logic                    sel,
    input  logic [1:0]              addr,
    input  logic [BUS_W-1:0]        wdata,
    input  logic                    load_en,
    input  logic                    acc_en,
    input  logic                    restart,
    input  logic                    carry_in,
    input  logic                    ofs_clr,
    output logic                    carry_out,
    output logic signed [OUT_W-1:0] cos_out,
    output logic signed [OUT_W-1:0] sin_out
);
    localparam int ACC_W = 2 * BUS_W;
    localparam int ARG_W = LUT_AW + 2;

    logic [BUS_W-1:0] sh_freq_lo, sh_freq_hi, sh_offset;
    logic [ACC_W-1:0] phase_q;
    logic [ARG_W-1:0] arg_q;

    nco_wport #(.BUS_W(BUS_W)) u_wport (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .sel(sel), .addr(addr),
        .wdata(wdata), .sh_freq_lo(sh_freq_lo), .sh_freq_hi(sh_freq_hi),
        .sh_offset(sh_offset)
    );

    nco_phase #(.BUS_W(BUS_W), .ARG_W(ARG_W)) u_phase (
        .clk(clk), .rst(rst), .load_en(load_en), .sh_freq_lo(sh_freq_lo),
        .sh_freq_hi(sh_freq_hi), .sh_offset(sh_offset), .acc_en(acc_en),
        .restart(restart), .carry_in(carry_in), .ofs_clr(ofs_clr),
        .phase_q(phase_q), .arg_q(arg_q), .carry_out(carry_out)
    );

    nco_sincos #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_sincos (
        .clk(clk), .rst(rst), .arg(arg_q), .cos_out(cos_out), .sin_out(sin_out)
    );
endmodule

// File: rtl/nco_quad_chk.sv
module nco_quad_chk #(
    parameter int ACC_W = 32,
    parameter int ARG_W = 12,
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    acc_en,
    input logic                    restart,
    input logic                    ofs_clr,
    input logic [ACC_W-1:0]        phase,
    input logic [ARG_W-1:0]        arg,
    input logic                    carry_out,
    input logic signed [OUT_W-1:0] cos_out,
    input logic signed [OUT_W-1:0] sin_out
);
    localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (carry_out == 1'b0 && cos_out == '0 && sin_out == '0 && phase == '0));

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_en && !restart) |=> $stable(phase));

    // R5
    no_carry_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_en || restart) |=> !carry_out);

    // R7
    clr_arg_chk: assert property (@(posedge clk) disable iff (rst)
        ofs_clr |=> (arg == $past(phase[ACC_W-1 -: ARG_W])));

    // R10
    out_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cos_out != MOST_NEG) && (sin_out != MOST_NEG));
endmodule

bind nco_quad nco_quad_chk #(.ACC_W(2*BUS_W), .ARG_W(LUT_AW+2), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst(rst), .acc_en(acc_en), .restart(restart), .ofs_clr(ofs_clr),
    .phase(phase_q), .arg(arg_q), .carry_out(carry_out),
    .cos_out(cos_out), .sin_out(sin_out)
);

// File: tb/tb_nco_quad.sv
module tb_nco_quad;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_stb = 0, sel = 0, load_en = 0, acc_en = 0, restart = 0, carry_in = 0, ofs_clr = 0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic carry_out;
    logic signed [15:0] cos_out, sin_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nco_quad dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .sel(sel), .addr(addr), .wdata(wdata),
        .load_en(load_en), .acc_en(acc_en), .restart(restart), .carry_in(carry_in),
        .ofs_clr(ofs_clr), .carry_out(carry_out), .cos_out(cos_out), .sin_out(sin_out)
    );

    // stimulus table: {ofs_clr, offset}; phase is zero throughout
    localparam logic [16:0] VEC [10] = '{
        {1'b0, 16'h0000}, {1'b0, 16'h4000}, {1'b0, 16'h8000}, {1'b0, 16'hC000},
        {1'b0, 16'h2000}, {1'b0, 16'h1230}, {1'b0, 16'h7FF0}, {1'b0, 16'hFFF0},
        {1'b1, 16'h4000}, {1'b0, 16'h3FF0}
    };

    function automatic int expect_val(logic [11:0] a, bit want_cos);
        real th, v;
        th = (real'(a) + 0.5) * 2.0 * 3.14159265358979323846 / 4096.0;
        v  = (want_cos ? $cos(th) : $sin(th)) * 32767.0;
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_angle(string req, logic [11:0] a);
        check(req, int'(cos_out), expect_val(a, 1'b1));
        check(req, int'(sin_out), expect_val(a, 1'b0));
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(logic [1:0] a, logic [15:0] d, logic s);
        @(negedge clk); wr_stb = 1; sel = s; addr = a; wdata = d;
        @(negedge clk); wr_stb = 0; sel = 0;
    endtask

    task automatic do_load();
        @(negedge clk); load_en = 1;
        @(negedge clk); load_en = 0;
    endtask

    task automatic set_freq(logic [31:0] f);
        wr_reg(2'd0, f[15:0], 1'b1);
        wr_reg(2'd1, f[31:16], 1'b1);
        do_load();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1: reset state
        check("R1 carry", int'(carry_out), 0);
        check("R1 cos", int'(cos_out), 0);
        check("R1 sin", int'(sin_out), 0);
        @(negedge clk); rst = 0;
        step(4);
        check_angle("R1 zero angle after reset", 12'h000);

        // R8: table walk, offsets with zero phase
        for (int i = 0; i < 10; i++) begin
            wr_reg(2'd2, VEC[i][15:0], 1'b1);
            do_load();
            ofs_clr = VEC[i][16];
            step(4);
            check_angle(VEC[i][16] ? "R7 ofs_clr" : "R8 table", VEC[i][16] ? 12'h000 : VEC[i][15:4]);
            ofs_clr = 0;
        end
        wr_reg(2'd2, 16'h0000, 1'b1);
        do_load();

        // R5: carry pattern with half-turn frequency
        set_freq(32'h8000_0000);
        acc_en = 1;
        step(1); check("R5 first half turn", int'(carry_out), 0);
        step(1); check("R5 wrap", int'(carry_out), 1);
        acc_en = 0;
        step(1); check("R5 idle", int'(carry_out), 0);

        // R4: five accumulate steps
        set_freq(32'h0100_0000);
        acc_en = 1; step(5); acc_en = 0;
        step(4);
        check_angle("R4 accumulate", 12'h050);

        // R4/R2 low half: all-ones word with carry_in keeps phase, carries each cycle
        set_freq(32'hFFFF_FFFF);
        acc_en = 1; carry_in = 1;
        step(1); check("R4 carry_in sum carry", int'(carry_out), 1);
        acc_en = 0; carry_in = 0;
        step(4);
        check_angle("R4 phase unchanged modulo", 12'h050);

        // R6: restart beats acc_en
        set_freq(32'h4000_0000);
        restart = 1; acc_en = 1;
        step(1); restart = 0; acc_en = 0;
        check("R6 restart carry", int'(carry_out), 0);
        step(4);
        check_angle("R6 restart phase", 12'h400);

        // R2: ignored writes
        wr_reg(2'd3, 16'h1234, 1'b1);
        wr_reg(2'd2, 16'h5000, 1'b0);
        do_load();
        step(4);
        check_angle("R2 ignored writes", 12'h400);

        // R2: held strobe captures once
        @(negedge clk); wr_stb = 1; sel = 1; addr = 2'd2; wdata = 16'h2000;
        @(negedge clk); wdata = 16'h6000;
        @(negedge clk); wr_stb = 0; sel = 0;
        do_load();
        step(4);
        check_angle("R2 held strobe", 12'h600);

        // R3: write and load on the same edge
        @(negedge clk); wr_stb = 1; sel = 1; addr = 2'd2; wdata = 16'h1000; load_en = 1;
        @(negedge clk); wr_stb = 0; sel = 0; load_en = 0;
        step(4);
        check_angle("R3 same edge keeps old", 12'h600);
        do_load();
        step(4);
        check_angle("R3 later load", 12'h500);

        // R3: write without load has no effect
        wr_reg(2'd2, 16'h3000, 1'b1);
        step(4);
        check_angle("R3 no load", 12'h500);

        // R9: latency of ofs_clr to outputs
        @(negedge clk); ofs_clr = 1;
        @(negedge clk); check_angle("R9 edge1 unchanged", 12'h500);
        @(negedge clk); check_angle("R9 edge2 unchanged", 12'h500);
        @(negedge clk); check_angle("R9 edge3 updated", 12'h400);
        ofs_clr = 0;

        // R1: reset in mid-run
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R1 mid reset cos", int'(cos_out), 0);
        step(4);
        check_angle("R1 registers cleared", 12'h000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule